// File: doc/BRIEF.md
# Virtually Indexed Mode-Tagged Cache

This block is a direct-mapped cache for a processor's external memory path. It holds instructions and data from both privilege levels. It is indexed and tagged by the virtual address, so the lookup runs in the same cycle that the translation unit produces its result. The physical address, the fault flag and the page's cache-inhibit flag arrive on the request port beside the virtual address. Each line carries one valid bit for user contents and one for supervisor contents. When software rewrites one mode's table base register, the logic around the block pulses a flush input, and only that mode's lines are dropped, in a single cycle.

Writes go straight through to memory and never allocate a line. Read misses fetch a whole 16-byte line over the memory port and install it for the requesting mode. Pages marked cache-inhibit bypass the array. When the enable input drops, every line is invalidated and the cache stays inert until the input returns high. Toggling the enable therefore acts as a full flush.

Top module: `vmt_cache`

## Requirements
- R1: After reset no line is valid in either mode, `req_ready` is high, and `resp_valid` and `mem_req` are low. The first access to any address goes to memory.
- R2: A cacheable read miss holds `mem_req` high with `mem_we` low and `mem_addr` set to the physical address with its low 4 bits cleared, until `mem_ack`. `mem_rdata` carries word w of the line in bits [32w+31:32w]. The response comes one cycle after `mem_ack`, returns word `req_vaddr[3:2]`, and the line is installed for the requesting mode.
- R3: A read hits when the tag (virtual address bits above the index) matches and the requesting mode's valid bit is set. `resp_valid` is then high in the cycle after acceptance, with the cached word and no memory access.
- R4: A line is valid for at most one mode. A line held by one mode misses for the other mode, and the other mode's refill takes the line away from the first.
- R5: The line index is virtual address bits [13:4] at the 16 KiB default (bits [14:4] at 32 KiB). Two addresses a cache size apart evict each other.
- R6: Every write is forwarded once to memory with `mem_we` high, `mem_addr` equal to the physical address and `mem_wdata` equal to the write data. The response comes one cycle after `mem_ack`. A write hit also updates the cached word. A write miss allocates nothing.
- R7: A pulse on `flush_user` invalidates every user line in one cycle and leaves supervisor lines hitting.
- R8: A pulse on `flush_super` invalidates every supervisor line in one cycle and leaves user lines hitting.
- R9: While `cache_en` is low, every access goes to memory and nothing is allocated. After `cache_en` returns high, all earlier lines of both modes miss.
- R10: A read with `xl_inhibit` set goes to memory even if its line is cached, and it allocates nothing.
- R11: A request with `xl_fault` set is answered in the cycle after acceptance with `resp_fault` high, makes no memory access and changes no cached data, whatever its hit and inhibit state.
- R12: If the requester's mode is flushed, or the cache is disabled, while its read miss is outstanding, the fetched line is returned but not installed. A flush of the other mode does not stop the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cache_en | input | 1 | Cache enable; low forces misses and clears all lines |
| flush_user | input | 1 | One-cycle pulse: drop all user lines |
| flush_super | input | 1 | One-cycle pulse: drop all supervisor lines |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_super | input | 1 | 1 = supervisor, 0 = user |
| req_vaddr | input | 32 | Virtual byte address |
| req_wdata | input | 32 | Write data |
| xl_paddr | input | 32 | Physical address from translation |
| xl_fault | input | 1 | Translation fault for this request |
| xl_inhibit | input | 1 | Page is cache-inhibited |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_data | output | 32 | Read data (zero for writes and faults) |
| resp_fault | output | 1 | Request was aborted by a fault |
| mem_req | output | 1 | Memory access pending |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory access complete |
| mem_rdata | input | 128 | Line returned by memory |

## Verification
A stale or missing valid bit appears at the ports in the cycle after the next request to that line is accepted. `mem_req` rises when a hit was expected, or `resp_valid` arrives one cycle after acceptance when a fetch was expected. A corrupted line word or tag shows as a wrong `resp_data` on that same response. A fill that should have been squashed shows only on the following access to the line, which then answers from the cache. The bench keeps its own picture of which mode owns which line and compares the memory traffic, latency and data of every access against it.

// File: rtl/vmt_cache_pkg.sv
package vmt_cache_pkg;

    localparam int ADDR_W = 32;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MEM  = 2'd1,
        ST_RESP = 2'd2
    } vmt_state_e;

    typedef struct packed {
        logic              write;
        logic              super_m;
        logic              alloc;
        logic [ADDR_W-1:0] vaddr;
        logic [ADDR_W-1:0] paddr;
        logic [WORD_W-1:0] wdata;
    } vmt_req_t;

    function automatic int line_count(input int kib, input int words);
        return (kib * 1024) / (words * 4);
    endfunction

    // True when the given mode's contents are being discarded this cycle.
    function automatic logic mode_kill(input logic super_m, input logic en,
                                       input logic fu, input logic fs);
        return !en || (super_m ? fs : fu);
    endfunction

endpackage

// File: rtl/vmt_tag_store.sv
module vmt_tag_store
    import vmt_cache_pkg::*;
#(
    parameter int LINES = 1024,
    parameter int IDX_W = 10,
    parameter int TAG_W = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cache_en,
    input  logic             flush_user,
    input  logic             flush_super,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_match,
    output logic             lk_vu,
    output logic             lk_vs,
    input  logic             fill_en,
    input  logic             fill_super,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag
);

    logic [TAG_W-1:0] tags [LINES];
    logic [LINES-1:0] valid_u;
    logic [LINES-1:0] valid_s;

    assign lk_match = (tags[lk_idx] == lk_tag);
    assign lk_vu    = valid_u[lk_idx];
    assign lk_vs    = valid_s[lk_idx];

    always_ff @(posedge clk) begin
        if (fill_en) tags[fill_idx] <= fill_tag;
    end

    // A fill makes the line exclusive to one mode; flushes clear whole vectors
    // and override a fill in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_u <= '0;
            valid_s <= '0;
        end else begin
            if (fill_en) begin
                valid_u[fill_idx] <= !fill_super;
                valid_s[fill_idx] <= fill_super;
            end
            if (flush_user || !cache_en)  valid_u <= '0;
            if (flush_super || !cache_en) valid_s <= '0;
        end
    end

    a_r4_one_mode_per_line: assert property (@(posedge clk) disable iff (rst)
        (valid_u & valid_s) == '0);

    a_r7_user_flush_clears: assert property (@(posedge clk) disable iff (rst)
        flush_user |=> (valid_u == '0));

    a_r8_super_flush_clears: assert property (@(posedge clk) disable iff (rst)
        flush_super |=> (valid_s == '0));

    a_r9_disable_clears: assert property (@(posedge clk) disable iff (rst)
        !cache_en |=> (valid_u == '0 && valid_s == '0));

    a_r1_reset_empty: assert property (@(posedge clk)
        $past(rst) |-> (valid_u == '0 && valid_s == '0));

endmodule

// File: rtl/vmt_data_store.sv
module vmt_data_store
    import vmt_cache_pkg::*;
#(
    parameter int LINES      = 1024,
    parameter int IDX_W      = 10,
    parameter int LINE_WORDS = 4,
    parameter int WSEL_W     = 2,
    parameter int LINE_W     = 128
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic [WSEL_W-1:0] lk_wsel,
    output logic [WORD_W-1:0] lk_word,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [LINE_W-1:0] fill_line,
    input  logic              wr_en,
    input  logic [WSEL_W-1:0] wr_sel,
    input  logic [WORD_W-1:0] wr_word
);

    logic [LINE_W-1:0] lines [LINES];
    logic [LINE_W-1:0] cur_line;
    logic [LINE_W-1:0] merged;

    assign cur_line = lines[lk_idx];
    assign lk_word  = cur_line[{lk_wsel, 5'b0} +: WORD_W];

    // Write hits replace one word of the indexed line.
    for (genvar w = 0; w < LINE_WORDS; w++) begin : g_merge
        assign merged[w*WORD_W +: WORD_W] =
            (wr_sel == WSEL_W'(w)) ? wr_word : cur_line[w*WORD_W +: WORD_W];
    end

    always_ff @(posedge clk) begin
        if (fill_en)    lines[fill_idx] <= fill_line;
        else if (wr_en) lines[lk_idx]   <= merged;
    end

endmodule

// File: rtl/vmt_ctrl.sv
module vmt_ctrl
    import vmt_cache_pkg::*;
#(
    parameter int IDX_W  = 10,
    parameter int TAG_W  = 18,
    parameter int OFF_W  = 4,
    parameter int WSEL_W = 2,
    parameter int LINE_W = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cache_en,
    input  logic              flush_user,
    input  logic              flush_super,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_super,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic [ADDR_W-1:0] xl_paddr,
    input  logic              xl_fault,
    input  logic              xl_inhibit,
    output logic [IDX_W-1:0]  lk_idx,
    output logic [TAG_W-1:0]  lk_tag,
    output logic [WSEL_W-1:0] lk_wsel,
    input  logic              lk_match,
    input  logic              lk_vu,
    input  logic              lk_vs,
    input  logic [WORD_W-1:0] lk_word,
    output logic              fill_en,
    output logic              fill_super,
    output logic [IDX_W-1:0]  fill_idx,
    output logic [TAG_W-1:0]  fill_tag,
    output logic              wr_en,
    output logic              resp_valid,
    output logic [WORD_W-1:0] resp_data,
    output logic              resp_fault,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [LINE_W-1:0] mem_rdata
);

    vmt_state_e        state;
    vmt_req_t          lat;
    logic              squash;
    logic [WORD_W-1:0] data_q;
    logic              fault_q;
    logic              accept;
    logic              hit;
    logic              kill_lat;
    logic [WORD_W-1:0] mem_word;
    logic              unused_lo;

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;

    assign lk_idx  = req_vaddr[OFF_W +: IDX_W];
    assign lk_tag  = req_vaddr[ADDR_W-1 -: TAG_W];
    assign lk_wsel = req_vaddr[2 +: WSEL_W];

    assign hit = cache_en && !xl_inhibit && lk_match && (req_super ? lk_vs : lk_vu);

    assign kill_lat = mode_kill(lat.super_m, cache_en, flush_user, flush_super);

    assign wr_en = accept && req_write && hit && !xl_fault;

    assign fill_en    = (state == ST_MEM) && mem_ack && lat.alloc && !squash && !kill_lat;
    assign fill_super = lat.super_m;
    assign fill_idx   = lat.vaddr[OFF_W +: IDX_W];
    assign fill_tag   = lat.vaddr[ADDR_W-1 -: TAG_W];

    assign mem_word  = mem_rdata[{lat.vaddr[2 +: WSEL_W], 5'b0} +: WORD_W];
    assign mem_req   = (state == ST_MEM);
    assign mem_we    = lat.write;
    assign mem_addr  = lat.write ? lat.paddr : {lat.paddr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    assign mem_wdata = lat.wdata;

    assign resp_valid = (state == ST_RESP);
    assign resp_data  = data_q;
    assign resp_fault = fault_q;

    assign unused_lo = ^{req_vaddr[1:0], lat.vaddr[1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            lat     <= '0;
            squash  <= 1'b0;
            data_q  <= '0;
            fault_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        if (xl_fault) begin
                            state   <= ST_RESP;
                            fault_q <= 1'b1;
                            data_q  <= '0;
                        end else if (!req_write && hit) begin
                            state   <= ST_RESP;
                            fault_q <= 1'b0;
                            data_q  <= lk_word;
                        end else begin
                            state       <= ST_MEM;
                            lat.write   <= req_write;
                            lat.super_m <= req_super;
                            lat.alloc   <= !req_write && cache_en && !xl_inhibit;
                            lat.vaddr   <= req_vaddr;
                            lat.paddr   <= xl_paddr;
                            lat.wdata   <= req_wdata;
                            squash      <= mode_kill(req_super, cache_en, flush_user, flush_super);
                        end
                    end
                end
                ST_MEM: begin
                    if (kill_lat) squash <= 1'b1;
                    if (mem_ack) begin
                        state   <= ST_RESP;
                        fault_q <= 1'b0;
                        data_q  <= lat.write ? '0 : mem_word;
                    end
                end
                ST_RESP: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    a_r11_fault_no_memory: assert property (@(posedge clk) disable iff (rst)
        (accept && xl_fault) |=> (resp_valid && resp_fault && !mem_req));

    a_r3_hit_next_cycle: assert property (@(posedge clk) disable iff (rst)
        (accept && !req_write && !xl_fault && hit) |=> (resp_valid && !mem_req));

    a_r6_write_forwarded: assert property (@(posedge clk) disable iff (rst)
        (accept && req_write && !xl_fault) |=> (mem_req && mem_we));

    a_r2_request_held: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    a_r2_single_response: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> (!resp_valid && req_ready));

    a_r12_no_fill_disabled: assert property (@(posedge clk) disable iff (rst)
        !cache_en |-> !fill_en);

endmodule

// File: rtl/vmt_cache.sv
module vmt_cache
    import vmt_cache_pkg::*;
#(
    parameter int CACHE_KB   = 16,
    parameter int LINE_WORDS = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cache_en,
    input  logic                       flush_user,
    input  logic                       flush_super,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic                       req_write,
    input  logic                       req_super,
    input  logic [31:0]                req_vaddr,
    input  logic [31:0]                req_wdata,
    input  logic [31:0]                xl_paddr,
    input  logic                       xl_fault,
    input  logic                       xl_inhibit,
    output logic                       resp_valid,
    output logic [31:0]                resp_data,
    output logic                       resp_fault,
    output logic                       mem_req,
    output logic                       mem_we,
    output logic [31:0]                mem_addr,
    output logic [31:0]                mem_wdata,
    input  logic                       mem_ack,
    input  logic [LINE_WORDS*32-1:0]   mem_rdata
);

    localparam int LINE_BYTES = LINE_WORDS * 4;
    localparam int OFF_W      = $clog2(LINE_BYTES);
    localparam int WSEL_W     = $clog2(LINE_WORDS);
    localparam int LINES      = line_count(CACHE_KB, LINE_WORDS);
    localparam int IDX_W      = $clog2(LINES);
    localparam int TAG_W      = ADDR_W - IDX_W - OFF_W;
    localparam int LINE_W     = LINE_WORDS * WORD_W;

    logic [IDX_W-1:0]  lk_idx;
    logic [TAG_W-1:0]  lk_tag;
    logic [WSEL_W-1:0] lk_wsel;
    logic              lk_match;
    logic              lk_vu;
    logic              lk_vs;
    logic [WORD_W-1:0] lk_word;
    logic              fill_en;
    logic              fill_super;
    logic [IDX_W-1:0]  fill_idx;
    logic [TAG_W-1:0]  fill_tag;
    logic              wr_en;

    vmt_ctrl #(
        .IDX_W(IDX_W), .TAG_W(TAG_W), .OFF_W(OFF_W), .WSEL_W(WSEL_W), .LINE_W(LINE_W)
    ) u_ctrl (
        .clk(clk), .rst(rst), .cache_en(cache_en),
        .flush_user(flush_user), .flush_super(flush_super),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_super(req_super), .req_vaddr(req_vaddr), .req_wdata(req_wdata),
        .xl_paddr(xl_paddr), .xl_fault(xl_fault), .xl_inhibit(xl_inhibit),
        .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_wsel(lk_wsel),
        .lk_match(lk_match), .lk_vu(lk_vu), .lk_vs(lk_vs), .lk_word(lk_word),
        .fill_en(fill_en), .fill_super(fill_super), .fill_idx(fill_idx),
        .fill_tag(fill_tag), .wr_en(wr_en),
        .resp_valid(resp_valid), .resp_data(resp_data), .resp_fault(resp_fault),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    vmt_tag_store #(
        .LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)
    ) u_tags (
        .clk(clk), .rst(rst), .cache_en(cache_en),
        .flush_user(flush_user), .flush_super(flush_super),
        .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_match(lk_match),
        .lk_vu(lk_vu), .lk_vs(lk_vs),
        .fill_en(fill_en), .fill_super(fill_super),
        .fill_idx(fill_idx), .fill_tag(fill_tag)
    );

    vmt_data_store #(
        .LINES(LINES), .IDX_W(IDX_W), .LINE_WORDS(LINE_WORDS),
        .WSEL_W(WSEL_W), .LINE_W(LINE_W)
    ) u_data (
        .clk(clk), .lk_idx(lk_idx), .lk_wsel(lk_wsel), .lk_word(lk_word),
        .fill_en(fill_en), .fill_idx(fill_idx), .fill_line(mem_rdata),
        .wr_en(wr_en), .wr_sel(lk_wsel), .wr_word(req_wdata)
    );

endmodule

// File: tb/sim_vmt_cache.sv
module sim_vmt_cache;

    localparam int LINES   = 1024;
    localparam int MEM_LAT = 2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cache_en = 1'b1;
    logic         flush_user = 1'b0;
    logic         flush_super = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic         req_write = 1'b0;
    logic         req_super = 1'b0;
    logic [31:0]  req_vaddr = '0;
    logic [31:0]  req_wdata = '0;
    logic [31:0]  xl_paddr = '0;
    logic         xl_fault = 1'b0;
    logic         xl_inhibit = 1'b0;
    logic         resp_valid;
    logic [31:0]  resp_data;
    logic         resp_fault;
    logic         mem_req;
    logic         mem_we;
    logic [31:0]  mem_addr;
    logic [31:0]  mem_wdata;
    logic         mem_ack = 1'b0;
    logic [127:0] mem_rdata = '0;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    // Behavioural model state
    logic [31:0]  memw   [logic [31:0]];
    int           m_line [int];
    int           m_mode [int];   // 0 none, 1 user, 2 supervisor
    logic [127:0] m_data [int];
    int           mem_cnt = 0;

    vmt_cache u0 (
        .clk(clk), .rst(rst), .cache_en(cache_en),
        .flush_user(flush_user), .flush_super(flush_super),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_super(req_super), .req_vaddr(req_vaddr), .req_wdata(req_wdata),
        .xl_paddr(xl_paddr), .xl_fault(xl_fault), .xl_inhibit(xl_inhibit),
        .resp_valid(resp_valid), .resp_data(resp_data), .resp_fault(resp_fault),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    always #10ns clk = ~clk;   // 50 MHz

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        logic [31:0] wa = {a[31:2], 2'b00};
        if (memw.exists(wa)) return memw[wa];
        return (wa * 32'h9E37_79B1) ^ 32'h5A5A_1234;
    endfunction

    function automatic logic [127:0] mem_line(input logic [31:0] a);
        logic [127:0] l;
        for (int w = 0; w < 4; w++)
            l[w*32 +: 32] = mem_word({a[31:4], 4'b0} + 32'(w * 4));
        return l;
    endfunction

    // Memory responder: acknowledges MEM_LAT cycles after seeing a request.
    always @(negedge clk) begin
        if (rst) begin
            mem_ack = 1'b0;
            mem_cnt = 0;
        end else if (mem_ack) begin
            mem_ack = 1'b0;
            mem_cnt = 0;
        end else if (mem_req) begin
            mem_cnt++;
            if (mem_cnt == MEM_LAT) begin
                mem_ack = 1'b1;
                if (mem_we) memw[{mem_addr[31:2], 2'b00}] = mem_wdata;
                else        mem_rdata = mem_line(mem_addr);
            end
        end
    end

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", total - fails, total);
        end
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic model_clear(input int mode);
        foreach (m_mode[i]) if (mode == 0 || m_mode[i] == mode) m_mode[i] = 0;
    endtask

    // One access, compared against the model: memory use, latency, address, data.
    task automatic acc(input bit wr, input bit sup, input logic [31:0] va,
                       input logic [31:0] wd, input bit flt, input bit inh,
                       input int midf, input string req);
        logic [31:0] pa = va ^ (sup ? 32'h0 : 32'h4000_0000);
        int idx = int'((va >> 4) % LINES);
        int ln  = int'(va >> 4);
        int w   = int'(va[3:2]);
        int own = sup ? 2 : 1;
        bit hit = cache_en && !inh && m_mode.exists(idx) && m_line[idx] == ln && m_mode[idx] == own;
        bit use_mem = !flt && (wr || !hit);
        logic [31:0] exp_data = (flt || wr) ? 32'h0 : (hit ? m_data[idx][w*32 +: 32] : mem_word(pa));
        logic [31:0] exp_addr = wr ? pa : {pa[31:4], 4'b0};
        bit seen = 0;
        bit sw = 0;
        logic [31:0] sa = '0;
        logic [31:0] sd = '0;
        int cyc = 0;
        bit en_at = cache_en;

        @(negedge clk);
        chk(req_ready, req, "ready before request", 32'(req_ready), 32'h1);
        req_valid = 1'b1; req_write = wr; req_super = sup; req_vaddr = va;
        req_wdata = wd; xl_paddr = pa; xl_fault = flt; xl_inhibit = inh;
        @(posedge clk);
        while (cyc < 30) begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) begin
                req_valid = 1'b0;
                if (midf == 1) begin flush_user = 1'b1;  model_clear(1); end
                if (midf == 2) begin flush_super = 1'b1; model_clear(2); end
            end else if (cyc == 2) begin
                flush_user = 1'b0; flush_super = 1'b0;
            end
            if (mem_req && !seen) begin
                seen = 1; sw = mem_we; sa = mem_addr; sd = mem_wdata;
            end
            if (resp_valid) break;
        end
        flush_user = 1'b0; flush_super = 1'b0;

        chk(seen == use_mem, req, "memory used", 32'(seen), 32'(use_mem));
        chk(cyc == (use_mem ? MEM_LAT + 1 : 1), req, "response latency", 32'(cyc),
            32'(use_mem ? MEM_LAT + 1 : 1));
        chk(resp_fault == flt, req, "fault flag", 32'(resp_fault), 32'(flt));
        chk(resp_data == exp_data, req, "response data", resp_data, exp_data);
        if (seen && use_mem) begin
            chk(sw == wr, req, "memory write flag", 32'(sw), 32'(wr));
            chk(sa == exp_addr, req, "memory address", sa, exp_addr);
            if (wr) chk(sd == wd, req, "memory write data", sd, wd);
        end

        if (!flt) begin
            if (wr && hit) m_data[idx][w*32 +: 32] = wd;
            if (!wr && !hit && en_at && !inh && midf != own) begin
                m_line[idx] = ln;
                m_mode[idx] = own;
                m_data[idx] = mem_line(pa);
            end
        end
    endtask

    task automatic rd(input bit sup, input logic [31:0] va, input string req);
        acc(0, sup, va, 32'h0, 0, 0, 0, req);
    endtask

    task automatic pulse_flush(input bit sup);
        @(negedge clk);
        if (sup) flush_super = 1'b1; else flush_user = 1'b1;
        @(negedge clk);
        flush_user = 1'b0; flush_super = 1'b0;
        model_clear(sup ? 2 : 1);
    endtask

    task automatic set_en(input bit v);
        @(negedge clk);
        cache_en = v;
        @(negedge clk);
        if (!v) model_clear(0);
    endtask

    initial begin
        #4ms;
        total++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: idle outputs after reset
        chk(req_ready == 1'b1, "R1", "req_ready after reset", 32'(req_ready), 32'h1);
        chk(resp_valid == 1'b0, "R1", "resp_valid after reset", 32'(resp_valid), 32'h0);
        chk(mem_req == 1'b0, "R1", "mem_req after reset", 32'(mem_req), 32'h0);

        // R1 R2 R3: first miss, then hits on the same line
        rd(0, 32'h0000_1000, "R1");
        rd(0, 32'h0000_1000, "R3");
        rd(0, 32'h0000_100C, "R3");

        // R4: the other mode misses and takes the line
        rd(1, 32'h0000_1000, "R4");
        rd(1, 32'h0000_1004, "R4");
        rd(0, 32'h0000_1000, "R4");

        // R5: 16 KiB apart collide
        rd(0, 32'h0000_5000, "R5");
        rd(0, 32'h0000_1000, "R5");
        rd(0, 32'h0000_1000, "R5");

        // R6: write hit updates line, write miss does not allocate
        acc(1, 0, 32'h0000_1004, 32'hCAFE_0001, 0, 0, 0, "R6");
        rd(0, 32'h0000_1004, "R6");
        acc(1, 0, 32'h0000_2008, 32'hBEEF_0002, 0, 0, 0, "R6");
        rd(0, 32'h0000_2008, "R6");

        // R7 R8: per-mode flushes
        rd(1, 32'h0000_3000, "R7");
        pulse_flush(0);
        rd(0, 32'h0000_1000, "R7");
        rd(1, 32'h0000_3000, "R7");
        pulse_flush(1);
        rd(1, 32'h0000_3000, "R8");
        rd(0, 32'h0000_1000, "R8");

        // R9: disabled cache misses and allocates nothing; re-enable leaves nothing valid
        set_en(0);
        rd(0, 32'h0000_1000, "R9");
        rd(0, 32'h0000_1000, "R9");
        set_en(1);
        rd(0, 32'h0000_1000, "R9");
        rd(1, 32'h0000_3000, "R9");
        rd(0, 32'h0000_1000, "R9");

        // R10: inhibited reads bypass and allocate nothing
        acc(0, 0, 32'h0000_6000, 32'h0, 0, 1, 0, "R10");
        rd(0, 32'h0000_6000, "R10");
        acc(0, 0, 32'h0000_1008, 32'h0, 0, 1, 0, "R10");

        // R11: faults abort hits, writes and inhibited accesses
        acc(0, 0, 32'h0000_1000, 32'h0, 1, 0, 0, "R11");
        acc(1, 0, 32'h0000_1004, 32'hDEAD_0003, 1, 0, 0, "R11");
        rd(0, 32'h0000_1004, "R11");
        acc(0, 1, 32'h0000_7000, 32'h0, 1, 1, 0, "R11");

        // R12: flush during an outstanding miss
        acc(0, 1, 32'h0000_8000, 32'h0, 0, 0, 2, "R12");
        rd(1, 32'h0000_8000, "R12");
        acc(0, 0, 32'h0000_9000, 32'h0, 0, 0, 2, "R12");
        rd(0, 32'h0000_9000, "R12");

        // R2 R3: a sweep of lines in both modes, then all hit
        for (int i = 0; i < 6; i++) rd(i[0], 32'h0002_0000 + 32'(i * 16 * 37), "R2");
        for (int i = 0; i < 6; i++) rd(i[0], 32'h0002_0004 + 32'(i * 16 * 37), "R3");

        summary();
        $finish;
    end

endmodule